// File: doc/BRIEF.md
# KR-Style FEC Transmit Encoder

This block adds forward error correction to one 64B/66B-coded Ethernet lane on its transmit side. Each 66-bit coded block is first shortened to a 65-bit word. The first sync bit is dropped, and the second sync bit is folded into payload bit 8 to form a single transcode bit. Thirty-two such words make a 2080-bit message. A shortened cyclic (2112,2080) code appends 32 parity bits to it. The whole 2112-bit codeword is then XORed with a pseudo-noise sequence from x^58 + x^39 + 1, which is restarted at every codeword.

Blocks arrive on a valid/ready handshake, one per cycle at most. The codeword leaves as 32 data beats followed by one parity beat. Start and end markers flag the first and last beats. Input ready falls for the single cycle in which the parity beat is formed, so 32 input cycles map onto 33 output cycles. A bypass input turns the whole function off, and the blocks then pass through untouched.

Top module: `kr_fec_tx_encoder`

## Requirements
- R1: Input bit 0 is sync bit S0, bit 1 is sync bit S1, and bits 2+i carry payload bit Di for i = 0..63. Before scrambling, a data beat holds the transcode bit S1 XOR D8 in bit 0 and Di in bit i+1. S0 is discarded, and out_data_o[65] is 0.
- R2: In FEC mode, every codeword leaves as 32 data beats followed by exactly one parity beat. out_sop_o is high on the first data beat only. out_eop_o is high on the parity beat only. The parity beat has bits 65:32 at zero.
- R3: Take the message polynomial with message bit 0 of word 0 as the highest-degree coefficient, and word bits taken LSB first, word after word. Before scrambling, bit k of the parity beat is the coefficient of x^(31-k) in (message · x^32) mod g(x), where g(x) = x^32+x^23+x^21+x^11+x^2+1.
- R4: At each codeword start, the 58-bit PN state is all ones. For each codeword bit, pn = s[57] XOR s[38], and the state shifts left with pn entering at bit 0. Each sent bit is the codeword bit XOR pn. Bits are taken in the order data beat bits 0..64, then parity beat bits 0..31.
- R5: A block accepted at a clock edge appears on the output after that same edge, so the latency is one cycle. The parity beat follows at the next edge after the 32nd data beat.
- R6: In FEC mode, in_ready_o is low for exactly one cycle after every 32nd accepted block, and no block is taken in that cycle.
- R7: In FEC mode, a cycle with no accepted block and no pending parity produces no output beat. Gaps between blocks do not alter the codeword.
- R8: With bypass_i high, in_ready_o is high. out_valid_o follows in_valid_i one cycle later with out_data_o equal to the input block, and both markers are low.
- R9: Raising bypass_i abandons any partial codeword. The next FEC-mode block starts a fresh codeword, with start marker, cleared parity and seeded PN state.
- R10: A synchronous reset clears out_valid_o, raises in_ready_o and makes the next block start a fresh codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_i | input | 1 | 1 = pass blocks through unchanged |
| in_valid_i | input | 1 | Input block valid |
| in_block_i | input | 66 | 64B/66B coded block (sync in bits 1:0) |
| in_ready_o | output | 1 | Block accepted when high with valid |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 66 | Scrambled data/parity beat, or raw block in bypass |
| out_sop_o | output | 1 | First data beat of a codeword |
| out_eop_o | output | 1 | Parity beat of a codeword |

## Verification
On every cycle, the assertions check the beat framing. They confirm that ready drops in the parity cycle, that an accepted block or a pending parity always yields a beat on the next edge, that idle cycles yield none, that the parity beat has its upper bits clear, and that bypass echoes the block with ready held high. Only the bench scenarios can show the actual bit values. These are the transcode mapping, the polynomial remainder, the PN sequence continuing across stalls, and the fresh restart after bypass or reset. The bench compares them against a long-division model and a bit-serial PN model.

// File: rtl/kr_fec_pkg.sv
package kr_fec_pkg;
  localparam int BLK_W  = 66;
  localparam int WORD_W = 65;
  localparam int PAR_W  = 32;
  localparam int SCR_W  = 58;
  localparam int SCR_TAP_HI = 57;
  localparam int SCR_TAP_LO = 38;
  localparam int D8_POS = 2 + 8;
  localparam logic [PAR_W-1:0] GEN_LOW = 32'h00A0_0805;

  typedef struct packed {
    logic [WORD_W-1:0] mask;
    logic [SCR_W-1:0]  next;
  } pn_run_t;

  function automatic logic [WORD_W-1:0] transcode(input logic [BLK_W-1:0] b);
    return {b[BLK_W-1:2], b[1] ^ b[D8_POS]};
  endfunction

  function automatic logic [PAR_W-1:0] parity_absorb(input logic [PAR_W-1:0] r_in,
                                                     input logic [WORD_W-1:0] w);
    logic [PAR_W-1:0] r;
    logic fb;
    r = r_in;
    for (int i = 0; i < WORD_W; i++) begin
      fb = w[i] ^ r[PAR_W-1];
      r  = {r[PAR_W-2:0], 1'b0} ^ ({PAR_W{fb}} & GEN_LOW);
    end
    return r;
  endfunction

  function automatic pn_run_t pn_run(input logic [SCR_W-1:0] s_in);
    pn_run_t o;
    logic [SCR_W-1:0] s;
    logic pn;
    s = s_in;
    o.mask = '0;
    for (int i = 0; i < WORD_W; i++) begin
      pn = s[SCR_TAP_HI] ^ s[SCR_TAP_LO];
      o.mask[i] = pn;
      s = {s[SCR_W-2:0], pn};
    end
    o.next = s;
    return o;
  endfunction
endpackage

// File: rtl/kr_fec_transcoder.sv
module kr_fec_transcoder
  import kr_fec_pkg::*;
(
  input  logic [BLK_W-1:0]  blk_i,
  output logic [WORD_W-1:0] word_o
);
  assign word_o = transcode(blk_i);
endmodule

// File: rtl/kr_fec_parity_lfsr.sv
module kr_fec_parity_lfsr
  import kr_fec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              absorb_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PAR_W-1:0]  rem_o
);
  logic [PAR_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  rem_q <= '0;
    else if (absorb_i) rem_q <= parity_absorb(rem_q, word_i);
  end

  // highest-degree coefficient goes out first (beat bit 0)
  for (genvar k = 0; k < PAR_W; k++) begin : g_order
    assign rem_o[k] = rem_q[PAR_W-1-k];
  end
endmodule

// File: rtl/kr_fec_pn_scrambler.sv
module kr_fec_pn_scrambler
  import kr_fec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] mask_o
);
  logic [SCR_W-1:0] st_q;
  pn_run_t          run_w;

  assign run_w  = pn_run(st_q);
  assign mask_o = run_w.mask;

  always_ff @(posedge clk) begin
    if (rst || seed_i) st_q <= '1;
    else if (step_i)   st_q <= run_w.next;
  end
endmodule

// File: rtl/kr_fec_beat_ctrl.sv
module kr_fec_beat_ctrl #(
  parameter int NUM_WORDS = 32,
  localparam int CNT_W = $clog2(NUM_WORDS)
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass_i,
  input  logic accept_i,
  output logic cw_start_o,
  output logic par_phase_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             par_q;

  always_ff @(posedge clk) begin
    if (rst || bypass_i) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (par_q) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (accept_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        par_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cw_start_o  = (cnt_q == '0);
  assign par_phase_o = par_q;
endmodule

// File: rtl/kr_fec_tx_encoder.sv
module kr_fec_tx_encoder
  import kr_fec_pkg::*;
#(
  parameter int NUM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic              in_valid_i,
  input  logic [BLK_W-1:0]  in_block_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BLK_W-1:0]  out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  localparam int PAR_PAD = BLK_W - PAR_W;

  logic              accept_w;
  logic              fec_word_w;
  logic              par_beat_w;
  logic              par_phase_w;
  logic              cw_start_w;
  logic [WORD_W-1:0] word_w;
  logic [WORD_W-1:0] mask_w;
  logic [PAR_W-1:0]  rem_w;

  assign in_ready_o = bypass_i | ~par_phase_w;
  assign accept_w   = in_valid_i & in_ready_o;
  assign fec_word_w = accept_w & ~bypass_i;
  assign par_beat_w = par_phase_w & ~bypass_i;

  kr_fec_beat_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .bypass_i(bypass_i), .accept_i(fec_word_w),
    .cw_start_o(cw_start_w), .par_phase_o(par_phase_w)
  );

  kr_fec_transcoder u_tc (.blk_i(in_block_i), .word_o(word_w));

  kr_fec_parity_lfsr u_par (
    .clk(clk), .rst(rst), .clr_i(par_beat_w | bypass_i),
    .absorb_i(fec_word_w), .word_i(word_w), .rem_o(rem_w)
  );

  kr_fec_pn_scrambler u_scr (
    .clk(clk), .rst(rst), .seed_i(par_beat_w | bypass_i),
    .step_i(fec_word_w), .mask_o(mask_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else if (bypass_i) begin
      out_valid_o <= in_valid_i;
      out_data_o  <= in_block_i;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else if (par_beat_w) begin
      out_valid_o <= 1'b1;
      out_data_o  <= {{PAR_PAD{1'b0}}, rem_w ^ mask_w[PAR_W-1:0]};
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b1;
    end else if (fec_word_w) begin
      out_valid_o <= 1'b1;
      out_data_o  <= {1'b0, word_w ^ mask_w};
      out_sop_o   <= cw_start_w;
      out_eop_o   <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/kr_fec_tx_encoder_chk.sv
module kr_fec_tx_encoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        bypass_i,
  input logic        in_valid_i,
  input logic [65:0] in_block_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic [65:0] out_data_o,
  input logic        out_sop_o,
  input logic        out_eop_o,
  input logic        accept_w,
  input logic        par_beat_w,
  input logic        cw_start_w
);
  p_par_stall_r6: assert property (@(posedge clk) disable iff (rst)
    par_beat_w |-> !in_ready_o && !accept_w);

  p_eop_follows_r2: assert property (@(posedge clk) disable iff (rst)
    par_beat_w |=> out_valid_o && out_eop_o && !out_sop_o);

  p_eop_shape_r2: assert property (@(posedge clk) disable iff (rst)
    out_eop_o |-> out_valid_o && !out_sop_o && (out_data_o[65:32] == '0));

  p_sop_mark_r2: assert property (@(posedge clk) disable iff (rst)
    (accept_w && !bypass_i && cw_start_w) |=> out_valid_o && out_sop_o);

  p_beat_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (accept_w && !bypass_i) |=> out_valid_o && !out_eop_o && !out_data_o[65]);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!bypass_i && !accept_w && !par_beat_w) |=> !out_valid_o);

  p_bypass_ready_r8: assert property (@(posedge clk) disable iff (rst)
    bypass_i |-> in_ready_o);

  p_bypass_echo_r8: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && in_valid_i) |=> out_valid_o && !out_sop_o && !out_eop_o
                                 && (out_data_o == $past(in_block_i)));
endmodule

bind kr_fec_tx_encoder kr_fec_tx_encoder_chk u_chk (
  .clk(clk), .rst(rst), .bypass_i(bypass_i), .in_valid_i(in_valid_i),
  .in_block_i(in_block_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
  .accept_w(accept_w), .par_beat_w(par_beat_w), .cw_start_w(cw_start_w)
);

// File: tb/kr_fec_tx_encoder_test.sv
module kr_fec_tx_encoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bypass = 1'b0;
  logic        in_valid = 1'b0;
  logic [65:0] in_block = '0;
  logic        in_ready, out_valid, out_sop, out_eop;
  logic [65:0] out_data;

  always #5 clk = ~clk;

  kr_fec_tx_encoder uut (
    .clk(clk), .rst(rst), .bypass_i(bypass), .in_valid_i(in_valid),
    .in_block_i(in_block), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_sop_o(out_sop), .out_eop_o(out_eop)
  );

  typedef struct {
    logic [65:0] d;
    logic        sop;
    logic        eop;
    int          cyc;
    string       req;
  } exp_t;

  exp_t  sb[$];
  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;

  logic [57:0] m_pn;
  bit          m_msg[0:2079];
  int          m_idx;
  bit          m_par_pending;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic m_restart();
    m_pn = '1;
    m_idx = 0;
  endtask

  task automatic pn_next(output logic b);
    b = m_pn[57] ^ m_pn[38];
    m_pn = {m_pn[56:0], b};
  endtask

  function automatic logic [31:0] long_div();
    bit a[0:2111];
    bit g[0:32];
    logic [31:0] r;
    for (int i = 0; i < 2112; i++) a[i] = (i < 2080) ? m_msg[i] : 1'b0;
    for (int j = 0; j <= 32; j++) g[j] = 1'b0;
    g[32] = 1; g[23] = 1; g[21] = 1; g[11] = 1; g[2] = 1; g[0] = 1;
    for (int i = 0; i < 2080; i++)
      if (a[i]) for (int j = 0; j <= 32; j++) a[i+j] = a[i+j] ^ g[32-j];
    for (int k = 0; k < 32; k++) r[k] = a[2080+k];
    return r;
  endfunction

  function automatic logic [63:0] next_rand();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
    if (n > 0) m_par_pending = 0;
  endtask

  // R1 R3 R4 R5 R6: drive one block in FEC mode and predict its beats
  task automatic drive_fec(input logic [65:0] blk, input string req);
    int waits;
    logic [64:0] w;
    logic [64:0] sw;
    logic [31:0] par;
    logic [31:0] spar;
    logic b;
    exp_t e;
    bypass = 1'b0;
    in_valid = 1'b1;
    in_block = blk;
    waits = 0;
    while (!in_ready) begin @(posedge clk); #1; waits++; end
    check(waits == (m_par_pending ? 1 : 0), "R6", "ready stall cycles",
          66'(waits), 66'(m_par_pending ? 1 : 0));
    m_par_pending = 0;
    for (int i = 0; i < 64; i++) w[i+1] = blk[2+i];
    w[0] = blk[1] ^ blk[10];
    for (int i = 0; i < 65; i++) begin
      pn_next(b);
      sw[i] = w[i] ^ b;
      m_msg[m_idx*65 + i] = w[i];
    end
    e.d = {1'b0, sw}; e.sop = (m_idx == 0); e.eop = 0; e.cyc = cyc + 1; e.req = req;
    sb.push_back(e);
    m_idx++;
    if (m_idx == 32) begin
      par = long_div();
      for (int k = 0; k < 32; k++) begin pn_next(b); spar[k] = par[k] ^ b; end
      e.d = {34'b0, spar}; e.sop = 0; e.eop = 1; e.cyc = cyc + 2; e.req = "R3";
      sb.push_back(e);
      m_restart();
      m_par_pending = 1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // R8 R9: bypass cycle
  task automatic drive_byp(input logic [65:0] blk, input bit v);
    exp_t e;
    bypass = 1'b1;
    in_valid = v;
    in_block = blk;
    m_restart();
    m_par_pending = 0;
    #1;
    check(in_ready == 1'b1, "R8", "ready in bypass", 66'(in_ready), 66'(1));
    if (v) begin
      e.d = blk; e.sop = 0; e.eop = 0; e.cyc = cyc + 1; e.req = "R8";
      sb.push_back(e);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [65:0] rand_blk(input int i);
    logic [63:0] p;
    p = next_rand();
    return {p, (i % 2 == 0) ? 2'b10 : 2'b01};
  endfunction

  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "unexpected beat", out_data, '0);
      end else begin
        e = sb.pop_front();
        check(out_data == e.d, e.req, "beat data", out_data, e.d);
        check(out_sop == e.sop, "R2", "start marker", 66'(out_sop), 66'(e.sop));
        check(out_eop == e.eop, "R2", "end marker", 66'(out_eop), 66'(e.eop));
        check(cyc == e.cyc, "R5", "beat cycle", 66'(cyc), 66'(e.cyc));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_restart();
    m_par_pending = 0;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    check(out_valid == 1'b0, "R10", "valid in reset", 66'(out_valid), 66'(0));
    check(in_ready == 1'b1, "R10", "ready in reset", 66'(in_ready), 66'(1));
    rst = 1'b0;

    // R4: all-zero blocks expose the raw PN sequence
    for (int i = 0; i < 32; i++) drive_fec('0, "R4");
    // R1: all-ones blocks, back to back with the parity stall
    for (int i = 0; i < 32; i++) drive_fec('1, "R1");
    // R7: random blocks with idle gaps
    for (int i = 0; i < 32; i++) begin
      drive_fec(rand_blk(i), "R7");
      if (i % 5 == 4) idle(2);
    end
    // R1 R3: two back-to-back random codewords
    for (int i = 0; i < 64; i++) drive_fec(rand_blk(i), "R1");
    idle(2);
    // R9: partial codeword, then bypass, then fresh codeword
    for (int i = 0; i < 10; i++) drive_fec(rand_blk(i), "R9");
    idle(1);
    drive_byp(rand_blk(1), 1'b1);
    drive_byp(rand_blk(2), 1'b0);
    drive_byp(66'h2_AAAA_5555_0F0F_F0F1, 1'b1);
    for (int i = 0; i < 32; i++) drive_fec(rand_blk(i), "R9");
    idle(2);
    // R10: reset mid-codeword, then fresh codeword
    for (int i = 0; i < 7; i++) drive_fec(rand_blk(i), "R10");
    idle(1);
    rst = 1'b1;
    m_restart();
    m_par_pending = 0;
    @(posedge clk); #1;
    check(in_ready == 1'b1, "R10", "ready after reset", 66'(in_ready), 66'(1));
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R10", "valid after reset", 66'(out_valid), 66'(0));
    rst = 1'b0;
    for (int i = 0; i < 32; i++) drive_fec(rand_blk(i), "R10");
    idle(4);
    check(sb.size() == 0, "R2", "beats left over", 66'(sb.size()), 66'(0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule